// File: doc/BRIEF.md
# Two-Address Register Execute Core

This block runs a stream of fixed 16-bit instructions against a file of sixteen 32-bit general registers. Each word holds four 4-bit fields. From most to least significant they are the major opcode (bits 15:12), the minor field (bits 11:8), the A register index (bits 7:4) and the B register index (bits 3:0). Register B is both the second operand and the destination. A register operation therefore reads registers A and B, combines them, and writes the result back into B.

There are two other instruction forms. A load-immediate form writes B from an 8-bit constant built from the minor and A fields and sign-extended to 32 bits. A count-leading-zeros form writes the number of leading zeros of register A into B. The block accepts one instruction in each cycle where the valid input is high. Any register can be read at any time through a combinational debug port. An undefined encoding writes nothing and raises a one-cycle illegal flag.

Top module: `exec_core`

## Requirements
- R1: While reset is low, all sixteen registers clear to zero and `illegalOp` is low.
- R2: Major opcode 1 writes B with the 8-bit value {minor, A} (minor is the high nibble), sign-extended from bit 7 to 32 bits.
- R3: Major opcode 0 with minor 0..7 writes B with f(regA, regB), where minor 0=add, 1=subtract (A minus B), 2=and, 3=or, 4=xor, 7=move (B gets A). No other register changes.
- R4: Minor 5 shifts regA left and minor 6 shifts regA right (logical). In both cases the shift amount is bits 4:0 of regB.
- R5: Major opcode 2 writes B with the count of leading zeros of regA. A value of zero gives 32.
- R6: A write takes effect at the clock edge that samples the instruction. The debug port (`dbgAddr` to `dbgData`, combinational) shows the new value in the following cycle.
- R7: While `instrValid` is low, no register changes, whatever `instrWord` holds.
- R8: Valid words with major opcode 3..15, or with major 0 and minor 8..15, leave every register unchanged. Such a word drives `illegalOp` high for exactly the cycle after its sampling edge. Legal or idle cycles leave it low.
- R9: When A equals B, the operation uses the same register for both operands (for example, subtract clears it).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| instrValid | input | 1 | Instruction word is valid this cycle |
| instrWord | input | 16 | Instruction: major, minor, A, B nibbles |
| dbgAddr | input | 4 | Debug read register index |
| dbgData | output | 32 | Contents of register dbgAddr |
| illegalOp | output | 1 | Previous valid word was undefined |

## Verification
The load form is swept over all 256 constants, spread across every destination register, so both sign-extension polarities and every B index are exercised. Every ALU function then runs for every A and B pair on values that keep changing. This separates mixed-up operand order, wrong destination selection and the A-equals-B aliasing case. All undefined major opcodes and all undefined minors are issued, and each one is followed by a full register-file comparison. This shows whether an illegal word leaks a write or whether the flag lasts too long. Count-leading-zeros is driven with a zero register and with single-bit values at every position, which pins down both ends of its range.

// File: rtl/exec_pkg.sv
package exec_pkg;
  typedef enum logic [3:0] {
    FN_ADD = 4'd0, FN_SUB = 4'd1, FN_AND = 4'd2, FN_OR  = 4'd3,
    FN_XOR = 4'd4, FN_SHL = 4'd5, FN_SHR = 4'd6, FN_MOV = 4'd7,
    FN_LDI = 4'd8, FN_CLZ = 4'd9
  } aluFn_e;

  typedef struct packed {
    logic   wrEn;
    logic   illegal;
    aluFn_e fn;
  } ctrlStrobes_t;

  localparam logic [3:0] MAJ_REG = 4'd0;
  localparam logic [3:0] MAJ_LDI = 4'd1;
  localparam logic [3:0] MAJ_CLZ = 4'd2;
  localparam int unsigned FIELD_W = 4;
endpackage

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               instrValid,
  input  logic [FIELD_W-1:0] major,
  input  logic [FIELD_W-1:0] minor,
  output ctrlStrobes_t       strb,
  output logic               illegalOp
);
  always_comb begin
    strb = '{wrEn: 1'b0, illegal: 1'b0, fn: FN_MOV};
    if (instrValid) begin
      unique case (major)
        MAJ_REG: begin
          if (!minor[FIELD_W-1]) begin
            strb.wrEn = 1'b1;
            strb.fn   = aluFn_e'(minor);
          end else begin
            strb.illegal = 1'b1;
          end
        end
        MAJ_LDI: begin
          strb.wrEn = 1'b1;
          strb.fn   = FN_LDI;
        end
        MAJ_CLZ: begin
          strb.wrEn = 1'b1;
          strb.fn   = FN_CLZ;
        end
        default: strb.illegal = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) illegalOp <= 1'b0;
    else        illegalOp <= strb.illegal;
  end

  // R8
  ill_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegalOp |-> $past(instrValid));
  // R8
  ill_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instrValid && major > MAJ_CLZ) |=> illegalOp);
  // R7
  idle_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instrValid |-> !strb.wrEn);
endmodule

// File: rtl/exec_dpath.sv
module exec_dpath
  import exec_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned REG_CNT = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  ctrlStrobes_t               strb,
  input  logic [$clog2(REG_CNT)-1:0] aAddr,
  input  logic [$clog2(REG_CNT)-1:0] bAddr,
  input  logic [7:0]                 imm8,
  input  logic [$clog2(REG_CNT)-1:0] dbgAddr,
  output logic [DATA_W-1:0]          dbgData
);
  localparam int unsigned SH_W  = $clog2(DATA_W);
  localparam int unsigned CNT_W = $clog2(DATA_W + 1);

  logic [REG_CNT-1:0][DATA_W-1:0] rf;
  logic [DATA_W-1:0] opA, opB, res;
  logic [CNT_W-1:0]  lzCnt;

  assign opA = rf[aAddr];
  assign opB = rf[bAddr];

  // The highest set bit is the last one the ascending loop sees.
  always_comb begin
    lzCnt = CNT_W'(DATA_W);
    for (int i = 0; i < DATA_W; i++)
      if (opA[i]) lzCnt = CNT_W'(DATA_W - 1 - i);
  end

  always_comb begin
    unique case (strb.fn)
      FN_ADD:  res = opA + opB;
      FN_SUB:  res = opA - opB;
      FN_AND:  res = opA & opB;
      FN_OR:   res = opA | opB;
      FN_XOR:  res = opA ^ opB;
      FN_SHL:  res = opA << opB[SH_W-1:0];
      FN_SHR:  res = opA >> opB[SH_W-1:0];
      FN_LDI:  res = {{(DATA_W-8){imm8[7]}}, imm8};
      FN_CLZ:  res = DATA_W'(lzCnt);
      default: res = opA;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rf <= '0;
    else if (strb.wrEn) rf[bAddr] <= res;
  end

  assign dbgData = rf[dbgAddr];

  // R7
  rf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.wrEn |=> $stable(rf));
  // R5
  clz_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrEn && strb.fn == FN_CLZ) |=> rf[$past(bAddr)] <= DATA_W);
  // R2
  ldi_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrEn && strb.fn == FN_LDI) |=>
      ($past(imm8[7]) ? (&rf[$past(bAddr)][DATA_W-1:7])
                      : !(|rf[$past(bAddr)][DATA_W-1:7])));
endmodule

// File: rtl/exec_core.sv
module exec_core
  import exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instrValid,
  input  logic [15:0]       instrWord,
  input  logic [3:0]        dbgAddr,
  output logic [DATA_W-1:0] dbgData,
  output logic              illegalOp
);
  localparam int unsigned REG_CNT = 1 << FIELD_W;

  ctrlStrobes_t strb;

  exec_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .instrValid (instrValid),
    .major      (instrWord[15:12]),
    .minor      (instrWord[11:8]),
    .strb       (strb),
    .illegalOp  (illegalOp)
  );

  exec_dpath #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) dpath_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .aAddr   (instrWord[7:4]),
    .bAddr   (instrWord[3:0]),
    .imm8    (instrWord[11:4]),
    .dbgAddr (dbgAddr),
    .dbgData (dbgData)
  );
endmodule

// File: tb/exec_core_tb.sv
module exec_core_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instrValid = 1'b0;
  logic [15:0] instrWord = '0;
  logic [3:0]  dbgAddr = '0;
  logic [31:0] dbgData;
  logic        illegalOp;

  int total = 0;
  int bad = 0;
  logic [31:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  exec_core dut_i (
    .clk(clk), .rst_n(rst_n), .instrValid(instrValid), .instrWord(instrWord),
    .dbgAddr(dbgAddr), .dbgData(dbgData), .illegalOp(illegalOp)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic readReg(input int idx, output logic [31:0] v);
    dbgAddr = 4'(idx);
    #1;
    v = dbgData;
  endtask

  task automatic checkAll(input string req);
    logic [31:0] v;
    for (int i = 0; i < 16; i++) begin
      readReg(i, v);
      chk(v === model[i], req, v, model[i]);
    end
  endtask

  function automatic logic [31:0] leadZeros(input logic [31:0] v);
    int n = 0;
    while (n < 32 && !v[31-n]) n++;
    return 32'(n);
  endfunction

  // Drives one word at a falling edge, updates the model, checks after the next edge.
  task automatic step(input logic [15:0] w, input bit v, input string req);
    logic [3:0] maj = w[15:12], mn = w[11:8], a = w[7:4], b = w[3:0];
    logic [31:0] ra = model[a], rb = model[b], r, got;
    bit wr = 1'b0, ill = 1'b0;
    if (v) begin
      if (maj == 4'd0 && mn < 4'd8) begin
        wr = 1'b1;
        case (mn)
          4'd0: r = ra + rb;
          4'd1: r = ra - rb;
          4'd2: r = ra & rb;
          4'd3: r = ra | rb;
          4'd4: r = ra ^ rb;
          4'd5: r = ra << rb[4:0];
          4'd6: r = ra >> rb[4:0];
          default: r = ra;
        endcase
      end else if (maj == 4'd1) begin
        wr = 1'b1; r = {{24{mn[3]}}, mn, a};
      end else if (maj == 4'd2) begin
        wr = 1'b1; r = leadZeros(ra);
      end else ill = 1'b1;
    end
    instrWord = w; instrValid = v;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    if (wr) model[b] = r;
    chk(illegalOp === ill, {req, " R8 flag"}, 32'(illegalOp), 32'(ill));
    if (wr) begin
      readReg(b, got);
      chk(got === model[b], req, got, model[b]);
    end else checkAll(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk(illegalOp === 1'b0, "R1 flag", 32'(illegalOp), 0);
    checkAll("R1 regs");

    // R2, R6: every constant, spread across all destinations
    for (int k = 0; k < 256; k++)
      step({4'd1, 8'(k), 4'(k * 7)}, 1'b1, "R2 load");

    // R3, R4, R9: all functions, all A/B pairs
    for (int f = 0; f < 8; f++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++) begin
          step({4'd0, 4'(f), 4'(a), 4'(b)}, 1'b1,
               (f == 5 || f == 6) ? "R4 shift" : (a == b ? "R9 alias" : "R3 alu"));
          if ((a + b) % 5 == 0) step({4'd1, 8'(a * 37 + b * 11 + f), 4'(b)}, 1'b1, "R2 reseed");
        end

    // R5: zero register and single-bit values
    step({4'd0, 4'd1, 4'd3, 4'd3}, 1'b1, "R9 sub self");
    step({4'd2, 4'd0, 4'd3, 4'd4}, 1'b1, "R5 clz zero");
    for (int p = 0; p < 32; p++) begin
      step({4'd1, 8'd1, 4'd5}, 1'b1, "R2 one");
      step({4'd1, 8'(p), 4'd6}, 1'b1, "R2 amount");
      step({4'd0, 4'd5, 4'd5, 4'd6}, 1'b1, "R4 build bit");
      step({4'd2, 4'd0, 4'd6, 4'd7}, 1'b1, "R5 clz bit");
    end
    for (int a = 0; a < 16; a++) step({4'd2, 4'd0, 4'(a), 4'(15 - a)}, 1'b1, "R5 clz mix");

    // R8: undefined majors and minors
    for (int m = 3; m < 16; m++) step({4'(m), 4'(m), 4'd2, 4'(m)}, 1'b1, "R8 major");
    for (int m = 8; m < 16; m++) step({4'd0, 4'(m), 4'd1, 4'(m)}, 1'b1, "R8 minor");
    step({4'd9, 12'h123}, 1'b1, "R8 back");
    step({4'd1, 8'h7f, 4'd0}, 1'b1, "R8 clears");

    // R7: idle cycles with writing words on the bus
    step({4'd1, 8'h80, 4'd0}, 1'b0, "R7 idle ldi");
    step({4'd0, 4'd0, 4'd1, 4'd2}, 1'b0, "R7 idle add");
    step({4'd4, 12'h000}, 1'b0, "R7 idle illegal");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule